// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 64-bit virtual address into a physical frame after a translation miss. It first classifies the address by its top two bits. The kernel segment is translated by taking address bits directly, with no memory traffic. The two user regions are translated by walking a three-level forward-mapped table held in memory. The walk starts at a root table whose frame number is supplied by the page-table base input. The walker reads one 64-bit entry per level through a simple read port: a held request with a one-cycle response strobe.

Pages are 8 KB. Each table fills exactly one page and holds 1024 entries. The 43 significant address bits split into three 10-bit indices above a 13-bit offset. The walk ends in one of three ways: a physical frame with the leaf entry's permission bits, a not-present fault that names the failing level, or an address fault for a non-canonical user address. Only one walk runs at a time. A busy output holds off new requests, and a one-cycle done pulse carries each outcome.

Top module: `ptw_walker`

## Requirements
- R1: Address bits 63:62 = 10 select the direct-mapped kernel region. Bit 63 = 0, or bits 63:62 = 11, select a user region that is translated through the tables.
- R2: An accepted kernel-region request gives done one cycle later, with fault low. It returns frame = va[44:13] and perm = 4'b0011 (kernel read and kernel write only), and it makes no memory request.
- R3: An accepted user-region request whose bits 62:43 are not all equal to bit 42 gives done one cycle later. It reports fault high, fault_kind = 2 and fault_level = 0, and it makes no memory request.
- R4: The read address at level L (0 = root) is {table frame, index_L, 3'b000}. The root table frame is ptbr. The indices are va[42:33], va[32:23] and va[22:13] for levels 0, 1 and 2.
- R5: Each valid non-leaf entry gives the next table frame in its bits 63:32. A successful walk makes exactly three reads.
- R6: While a read waits for mem_rsp_valid, mem_req stays high and mem_addr stays unchanged.
- R7: An entry with bit 0 (valid) clear ends the walk at once with no further reads. It reports fault high, fault_kind = 1 and fault_level = L.
- R8: On success, frame = leaf entry bits 63:32 and perm = leaf entry bits 4:1. The perm bits are, from bit 0 up: kernel-read, kernel-write, user-read, user-write. On any fault, frame and perm are zero.
- R9: busy is high from the cycle after a user request is accepted until its result. A request presented while busy is ignored and produces no result. done lasts one cycle per accepted request.
- R10: After reset, busy, done, mem_req and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_va | input | 64 | Virtual address to translate |
| ptbr | input | 32 | Frame number of the root table |
| busy | output | 1 | Walk in progress; requests are ignored |
| mem_req | output | 1 | Table read request, held until response |
| mem_addr | output | 45 | Physical byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle pulse with the result |
| fault | output | 1 | Result is a fault |
| fault_kind | output | 2 | 1 = not present, 2 = address fault |
| fault_level | output | 2 | Level of a not-present fault |
| pa_frame | output | 32 | Translated physical frame number |
| perm | output | 4 | Permission bits of the translation |

## Verification
The embedded properties watch the cycle-level behaviour on every clock. They check that a pending read keeps its request and address steady, and that kernel and non-canonical requests finish in one cycle without touching memory. They also check that done never coincides with busy, and that a fault never carries a frame. Only the bench scenarios can show the table walk itself. It builds tables in a memory model, so a wrong index or frame composition lands on an empty entry and shows up as a fault. The scenarios also check the number of reads per walk, the level reported by a not-present fault at each depth, the permissions taken from the leaf, and that a request presented while busy produces no result.

// File: rtl/ptw_pkg.sv
// Shared constants and encodings for the page table walker.
// Assumes 64-bit entries with the frame in the upper half.
package ptw_pkg;
    localparam int VA_W   = 64;
    localparam int OFF_W  = 13;
    localparam int IDX_W  = 10;
    localparam int LEVELS = 3;
    localparam int PTE_W  = 64;
    localparam int PFN_W  = 32;
    localparam int ENT_SH = $clog2(PTE_W / 8);
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int SIG_W  = OFF_W + LEVELS * IDX_W;
    localparam int LVL_W  = $clog2(LEVELS);

    typedef enum logic [1:0] {
        FK_NONE    = 2'd0,
        FK_NOTPRES = 2'd1,
        FK_ADDR    = 2'd2
    } fault_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;
endpackage

// File: rtl/ptw_region_dec.sv
// Region decoder: classifies a virtual address by its top two bits and
// checks that a user address is canonical (bits above the significant
// field repeat the top significant bit). Purely combinational.
module ptw_region_dec
    import ptw_pkg::*;
#(
    parameter int VW = VA_W,
    parameter int SW = SIG_W
) (
    input  logic [VW-1:0] va,
    output logic          is_kernel,
    output logic          canon_ok
);
    localparam int EXT_W = VW - 1 - SW;

    // Kernel segment is the 10 pattern; the user regions are 0x and 11.
    assign is_kernel = (va[VW-1:VW-2] == 2'b10);
    // Sign-extension check on the bits between the top bit and the field.
    assign canon_ok  = (va[VW-2:SW] == {EXT_W{va[SW-1]}});
endmodule

// File: rtl/ptw_addr_gen.sv
// Entry address former: selects the index field for the current level
// and scales it by the entry size within the current table frame.
// Assumes one table per page, so index plus scale fills the offset.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int NLVL = LEVELS,
    parameter int IW   = IDX_W,
    parameter int OW   = OFF_W,
    parameter int FW   = PFN_W,
    parameter int LW   = LVL_W
) (
    input  logic [VA_W-1:0]  va,
    input  logic [FW-1:0]    tbl_frame,
    input  logic [LW-1:0]    lvl,
    output logic [FW+OW-1:0] ent_addr
);
    localparam int SH = OW - IW;

    logic [IW-1:0] idx [NLVL];

    // One index field per level, root level taken from the highest bits.
    for (genvar g = 0; g < NLVL; g++) begin : g_idx
        assign idx[g] = va[OW + IW * (NLVL - 1 - g) +: IW];
    end

    // Compose the byte address of the entry.
    assign ent_addr = {tbl_frame, idx[lvl], {SH{1'b0}}};
endmodule

// File: rtl/ptw_walker.sv
// Page table walker top: accepts one translation at a time, resolves
// kernel addresses directly, rejects non-canonical user addresses, and
// walks three table levels for user addresses through a held read port.
// Assumes memory answers each held request with a one-cycle strobe.
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [63:0]      req_va,
    input  logic [31:0]      ptbr,
    output logic             busy,
    output logic             mem_req,
    output logic [44:0]      mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_kind,
    output logic [1:0]       fault_level,
    output logic [31:0]      pa_frame,
    output logic [3:0]       perm
);
    localparam logic [3:0] KERN_PERM = 4'b0011;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e      state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [VA_W-1:0]  va_q;
    logic [PFN_W-1:0] tbl_q;
    logic             is_kernel, canon_ok, accept;

    ptw_region_dec u_dec (
        .va        (req_va),
        .is_kernel (is_kernel),
        .canon_ok  (canon_ok)
    );

    ptw_addr_gen u_agen (
        .va        (va_q),
        .tbl_frame (tbl_q),
        .lvl       (lvl_q),
        .ent_addr  (mem_addr)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign busy    = (state_q == ST_WALK);
    assign mem_req = (state_q == ST_WALK);

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lvl_q       <= '0;
            va_q        <= '0;
            tbl_q       <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            fault_kind  <= FK_NONE;
            fault_level <= '0;
            pa_frame    <= '0;
            perm        <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (is_kernel) begin
                    done        <= 1'b1;
                    fault       <= 1'b0;
                    fault_kind  <= FK_NONE;
                    fault_level <= '0;
                    pa_frame    <= req_va[OFF_W +: PFN_W];
                    perm        <= KERN_PERM;
                end else if (!canon_ok) begin
                    done        <= 1'b1;
                    fault       <= 1'b1;
                    fault_kind  <= FK_ADDR;
                    fault_level <= '0;
                    pa_frame    <= '0;
                    perm        <= '0;
                end else begin
                    state_q <= ST_WALK;
                    lvl_q   <= '0;
                    va_q    <= req_va;
                    tbl_q   <= ptbr;
                end
            end else if (state_q == ST_WALK && mem_rsp_valid) begin
                if (!mem_rsp_data[0]) begin
                    state_q     <= ST_IDLE;
                    done        <= 1'b1;
                    fault       <= 1'b1;
                    fault_kind  <= FK_NOTPRES;
                    fault_level <= lvl_q;
                    pa_frame    <= '0;
                    perm        <= '0;
                end else if (lvl_q == LAST_LVL) begin
                    state_q     <= ST_IDLE;
                    done        <= 1'b1;
                    fault       <= 1'b0;
                    fault_kind  <= FK_NONE;
                    fault_level <= '0;
                    pa_frame    <= mem_rsp_data[PTE_W-1 -: PFN_W];
                    perm        <= mem_rsp_data[4:1];
                end else begin
                    lvl_q <= lvl_q + 1'b1;
                    tbl_q <= mem_rsp_data[PTE_W-1 -: PFN_W];
                end
            end
        end
    end

    // R6: a pending read keeps its request and address.
    p_hold_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R2: kernel requests finish next cycle without memory traffic.
    p_kernel_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_kernel) |=> (done && !fault && !mem_req));

    // R3: non-canonical user requests fault next cycle without reads.
    p_addr_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_kernel && !canon_ok) |=>
            (done && fault && fault_kind == FK_ADDR && !mem_req));

    // R9: a result is never reported while a walk is still running.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a fault never carries a frame or permissions.
    p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (pa_frame == '0 && perm == '0));

    // R7: the walk level never leaves the three table levels.
    p_level_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (lvl_q <= LAST_LVL));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [31:0] ptbr = 32'h100;
    logic        busy, mem_req, done, fault;
    logic [44:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [1:0]  fault_kind, fault_level;
    logic [31:0] pa_frame;
    logic [3:0]  perm;

    typedef struct {
        logic [31:0] frame;
        logic [3:0]  perm;
        logic        fault;
        logic [1:0]  kind;
        logic [1:0]  level;
        int          reads;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] mem[logic [44:0]];
    int          n_cmp = 0, n_bad = 0, reads = 0, n_done = 0, n_push = 0;
    int          lat = 0;

    always #4 clk = ~clk;

    ptw_walker dut (.*);

    function automatic logic [44:0] ent(input logic [31:0] f, input logic [9:0] i);
        return {f, i, 3'b000};
    endfunction

    function automatic logic [63:0] pte(input logic [31:0] f, input logic [3:0] p, input logic v);
        return {f, 27'd0, p, v};
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
        end
    endtask

    // Memory model: answers a held request after a fixed wait.
    always @(negedge clk) begin
        if (mem_req) begin
            if (lat == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
                lat = 0;
            end else begin
                mem_rsp_valid <= 1'b0;
                lat++;
            end
        end else begin
            mem_rsp_valid <= 1'b0;
            lat = 0;
        end
    end

    always @(posedge clk) if (rst_n && mem_req && mem_rsp_valid) reads++;

    // Monitor: pop and compare each result.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sb.size() == 0) begin
                chk("R9 unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " fault"}, 64'(fault), 64'(e.fault));
                chk({e.req, " frame"}, 64'(pa_frame), 64'(e.frame));
                chk({e.req, " perm"}, 64'(perm), 64'(e.perm));
                chk({e.req, " reads"}, 64'(reads), 64'(e.reads));
                if (e.fault) begin
                    chk({e.req, " kind"}, 64'(fault_kind), 64'(e.kind));
                    chk({e.req, " level"}, 64'(fault_level), 64'(e.level));
                end
            end
            reads = 0;
        end
    end

    // Driver: computes the expected outcome from the requirements and issues.
    task automatic issue(input logic [63:0] va, input string r);
        exp_t e;
        logic [31:0] f;
        logic [63:0] d;
        e = '{frame: 0, perm: 0, fault: 0, kind: 0, level: 0, reads: 0, req: r};
        if (va[63:62] == 2'b10) begin
            e.frame = va[44:13];
            e.perm  = 4'b0011;
        end else if (va[62:43] != {20{va[42]}}) begin
            e.fault = 1'b1;
            e.kind  = 2'd2;
        end else begin
            f = ptbr;
            for (int l = 0; l < 3; l++) begin
                logic [44:0] a;
                a = ent(f, va[42 - 10*l -: 10]);
                d = mem.exists(a) ? mem[a] : 64'd0;
                e.reads++;
                if (!d[0]) begin
                    e.fault = 1'b1;
                    e.kind  = 2'd1;
                    e.level = 2'(l);
                    break;
                end
                f = d[63:32];
                if (l == 2) begin
                    e.frame = d[63:32];
                    e.perm  = d[4:1];
                end
            end
        end
        while (busy) @(negedge clk);
        sb.push_back(e);
        n_push++;
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (va[63:62] != 2'b10 && e.kind != 2'd2)
            chk({r, " R9 busy after accept"}, 64'(busy), 64'd1);
        else
            chk({r, " no read R2/R3"}, 64'(mem_req), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Tables: root 0x100. Walk A idx 1/2/3, walk B stack region.
        mem[ent(32'h100, 10'd1)]   = pte(32'h200, 4'h0, 1'b1);
        mem[ent(32'h200, 10'd2)]   = pte(32'h300, 4'h0, 1'b1);
        mem[ent(32'h300, 10'd3)]   = pte(32'hABCDE, 4'b0101, 1'b1);
        mem[ent(32'h300, 10'd4)]   = pte(32'h12345, 4'b1111, 1'b1);
        mem[ent(32'h300, 10'd5)]   = pte(32'h777, 4'b1100, 1'b0);
        mem[ent(32'h200, 10'd6)]   = pte(32'h400, 4'h0, 1'b0);
        mem[ent(32'h100, 10'd1023)] = pte(32'h500, 4'h0, 1'b1);
        mem[ent(32'h500, 10'd1023)] = pte(32'h600, 4'h0, 1'b1);
        mem[ent(32'h600, 10'd1022)] = pte(32'hFEED0, 4'b1010, 1'b1);

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", 64'(busy), 64'd0);
        chk("R10 done", 64'(done), 64'd0);
        chk("R10 mem_req", 64'(mem_req), 64'd0);
        chk("R10 fault", 64'(fault), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue({2'b10, 17'd0, 32'hCAFE1, 13'h1FFF}, "R2 kernel a");
        issue({2'b10, 49'h1_2345_6789_ABCD, 13'd0}, "R2 kernel b");
        issue({1'b0, 20'h00010, 43'd0}, "R3 noncanon low");
        issue({2'b11, 19'h7FFFF, 1'b0, 42'd5}, "R3 noncanon stack");
        issue({21'd0, 10'd1, 10'd2, 10'd3, 13'h0AA}, "R4 R5 R8 walk a");
        issue({21'd0, 10'd1, 10'd2, 10'd4, 13'h000}, "R8 walk perms");
        issue({21'h1FFFFF, 10'd1023, 10'd1023, 10'd1022, 13'h5}, "R1 R4 stack walk");
        issue({21'd0, 10'd0, 10'd2, 10'd3, 13'h0}, "R7 level0");
        issue({21'd0, 10'd1, 10'd6, 10'd3, 13'h0}, "R7 level1");
        issue({21'd0, 10'd1, 10'd2, 10'd5, 13'h0}, "R7 level2");

        // R9: a request made while busy is ignored.
        issue({21'd0, 10'd1, 10'd2, 10'd3, 13'h0}, "R9 walk before ignored req");
        req_valid = 1'b1;
        req_va    = {2'b10, 62'd77};
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 results match accepted requests", 64'(n_done), 64'(n_push));
        chk("R9 scoreboard drained", 64'(sb.size()), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule